// File: doc/BRIEF.md
# Background Debug Activation and Address Overlay

This block decides when a processor is in its background debug state, and it steers the processor's accesses to the top of the address space while that state holds. It keeps two bits of state. The enable bit says whether debug may be entered. The active bit says whether debug is in force. The operating-mode code sets the initial value of both bits during reset. After reset, either of two triggers makes the block active: a command decoded from the serial debug wire, or the CPU executing its background instruction. An exit request ends the active state.

While the block is active, accesses at or above the debug ROM base go to the debug ROM. A short window of debug control registers sits just below the ROM. Addresses between the register window and the ROM base select nothing. Every other access goes to normal memory, as does every access made while the block is inactive. The window positions and sizes are parameters. The serial protocol and the ROM contents belong to other blocks.

Top module: `dbg_overlay_top`

## Requirements
- R1: While `rst_ni` is low, the block samples `mode_i` on each clock edge and keeps the last value after reset. Mode code 2'b10 (special single-chip) leaves the block enabled and active after reset. Codes 2'b00 (normal single-chip), 2'b01 (normal expanded) and 2'b11 (special peripheral) leave it disabled and inactive.
- R2: When `en_wr_i` is high and the block is inactive and not becoming active, `en_wdata_i` is loaded into the enable bit at the next edge. While the block is active, or in the cycle it becomes active, an enable write is ignored.
- R3: When the block is enabled and inactive, and the mode is not 2'b11, a high on `ser_trig_i` or `bgnd_trig_i` makes `dbg_active_o` high from the next edge.
- R4: A trigger that arrives while the block is disabled changes neither the active bit nor the enable bit.
- R5: In mode 2'b11 every trigger is ignored, even when enabled, and `dbg_active_o` never goes high.
- R6: When `exit_req_i` is high while the block is active, `dbg_active_o` falls at the next edge and `dbg_enabled_o` stays high. Exit takes precedence over a trigger in the same cycle. An exit request while the block is inactive has no effect.
- R7: While the block is active and `cpu_strb_i` is high, addresses from `ROM_BASE` (default 16'hFF20) to the top of the address space assert only `rom_sel_o`.
- R8: While the block is active and `cpu_strb_i` is high, addresses from `REG_BASE` (default 16'hFF00) through `REG_BASE+REG_COUNT-1` (default 7 registers, up to 16'hFF06) assert only `reg_sel_o`. `reg_ofs_o` then equals the address minus `REG_BASE`, and it is 0 at all other times.
- R9: While the block is active and `cpu_strb_i` is high, addresses after the register window and below `ROM_BASE` (default 16'hFF07 to 16'hFF1F) assert no select.
- R10: When `cpu_strb_i` is high, `mem_sel_o` alone is asserted for every address while the block is inactive, and for addresses below `REG_BASE` while it is active.
- R11: When `cpu_strb_i` is low, all selects and `reg_ofs_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Operating-mode code, sampled during reset |
| en_wr_i | input | 1 | Enable-bit write strobe |
| en_wdata_i | input | 1 | Value for the enable bit |
| ser_trig_i | input | 1 | Decoded serial debug activation command |
| bgnd_trig_i | input | 1 | CPU executed the background instruction |
| exit_req_i | input | 1 | Request to leave the active state |
| cpu_addr_i | input | ADDR_W | CPU access address |
| cpu_strb_i | input | 1 | CPU access strobe |
| dbg_active_o | output | 1 | Debug active |
| dbg_enabled_o | output | 1 | Debug enabled |
| rom_sel_o | output | 1 | Debug ROM selected |
| reg_sel_o | output | 1 | Debug control register selected |
| reg_ofs_o | output | REG_OFS_W | Register index inside the window |
| mem_sel_o | output | 1 | Normal memory selected |

## Verification
The bench builds the block with its defaults: a 16-bit address, a seven-entry register window at 16'hFF00, and the ROM from 16'hFF20 to the top. A seven-entry window is not a power of two. The defaults therefore use the magnitude-compare decoder variant and the top-ended ROM variant, and they leave a non-empty gap of 25 addresses that selects nothing. With these values, every boundary address (16'hFEFF, 16'hFF00, 16'hFF06, 16'hFF07, 16'hFF1F, 16'hFF20, 16'hFFFF) can be reached as a directed case. The bench runs random trigger, exit and enable streams after a reset in each of the four mode codes.

// File: rtl/dbg_ovl_pkg.sv
package dbg_ovl_pkg;

   typedef enum logic [1:0] {
      MODE_NORM_SC     = 2'b00,
      MODE_NORM_EXP    = 2'b01,
      MODE_SPEC_SC     = 2'b10,
      MODE_SPEC_PERIPH = 2'b11
   } op_mode_e;

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
   import dbg_ovl_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] mode_i,
   input  logic       en_wr_i,
   input  logic       en_wdata_i,
   input  logic       ser_trig_i,
   input  logic       bgnd_trig_i,
   input  logic       exit_req_i,
   output logic       act_o,
   output logic       en_o
);

   op_mode_e mode_q;
   logic     en_q, act_q;
   logic     en_d, act_d;
   logic     any_trig, trig_gate, wr_ok;

   assign any_trig  = ser_trig_i | bgnd_trig_i;
   assign trig_gate = en_q & ~act_q & (mode_q != MODE_SPEC_PERIPH);

   always_comb begin
      if (act_q) act_d = ~exit_req_i;
      else       act_d = trig_gate & any_trig;
   end

   assign wr_ok = en_wr_i & ~act_q & ~act_d;
   assign en_d  = wr_ok ? en_wdata_i : en_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= op_mode_e'(mode_i);
         en_q   <= (mode_i == MODE_SPEC_SC);
         act_q  <= (mode_i == MODE_SPEC_SC);
      end else begin
         en_q   <= en_d;
         act_q  <= act_d;
      end
   end

   assign act_o = act_q;
   assign en_o  = en_q;

   // R5
   periph_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_SPEC_PERIPH) |-> !act_q);

   // R4
   no_trig_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_q && !(en_q && any_trig)) |=> !act_q);

   // R3
   act_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_q && en_q && any_trig && mode_q != MODE_SPEC_PERIPH) |=> act_q);

   // R6
   exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q && exit_req_i) |=> (!act_q && en_q));

   // R2
   en_hold_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_q |=> $stable(en_q));

endmodule

// File: rtl/dbg_range_cmp.sv
module dbg_range_cmp
   import dbg_ovl_pkg::*;
#(
   parameter int                ADDR_W = 16,
   parameter logic [ADDR_W-1:0] LO     = '0,
   parameter logic [ADDR_W-1:0] HI     = '1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);

   localparam logic [ADDR_W-1:0] SPAN    = HI - LO;
   localparam bit                ALIGNED = is_pow2(longint'(SPAN) + 1) && ((LO & SPAN) == '0);
   localparam bit                TOP_END = (HI == {ADDR_W{1'b1}});
   localparam bit                BOT_END = (LO == '0);

   if (HI < LO) begin : g_bad
      $error("dbg_range_cmp: HI below LO");
   end

   if (ALIGNED) begin : g_mask
      assign hit_o = ((addr_i & ~SPAN) == LO);
   end else if (TOP_END) begin : g_top
      assign hit_o = (addr_i >= LO);
   end else if (BOT_END) begin : g_bot
      assign hit_o = (addr_i <= HI);
   end else begin : g_mag
      assign hit_o = (addr_i >= LO) && (addr_i <= HI);
   end

endmodule

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] REG_BASE  = 16'hFF00,
   parameter int                REG_COUNT = 7,
   parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hFF20,
   localparam int               REG_OFS_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 act_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 strb_i,
   output logic                 rom_sel_o,
   output logic                 reg_sel_o,
   output logic [REG_OFS_W-1:0] reg_ofs_o,
   output logic                 mem_sel_o
);

   localparam logic [ADDR_W-1:0] REG_LAST   = REG_BASE + ADDR_W'(REG_COUNT - 1);
   localparam logic [ADDR_W-1:0] HOLE_LO    = REG_LAST + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] HOLE_HI    = ROM_BASE - ADDR_W'(1);
   localparam bit                HOLE_EMPTY = (HOLE_LO == ROM_BASE);

   logic hit_rom, hit_reg, hit_hole, overlay;

   dbg_range_cmp #(.ADDR_W(ADDR_W), .LO(ROM_BASE), .HI({ADDR_W{1'b1}})) u_rom_cmp (
      .addr_i (addr_i),
      .hit_o  (hit_rom)
   );

   dbg_range_cmp #(.ADDR_W(ADDR_W), .LO(REG_BASE), .HI(REG_LAST)) u_reg_cmp (
      .addr_i (addr_i),
      .hit_o  (hit_reg)
   );

   if (HOLE_EMPTY) begin : g_no_hole
      assign hit_hole = 1'b0;
   end else begin : g_hole
      dbg_range_cmp #(.ADDR_W(ADDR_W), .LO(HOLE_LO), .HI(HOLE_HI)) u_hole_cmp (
         .addr_i (addr_i),
         .hit_o  (hit_hole)
      );
   end

   assign overlay   = strb_i & act_i;
   assign rom_sel_o = overlay & hit_rom;
   assign reg_sel_o = overlay & hit_reg;
   assign mem_sel_o = strb_i & ~(act_i & (hit_rom | hit_reg | hit_hole));
   assign reg_ofs_o = reg_sel_o ? REG_OFS_W'(addr_i - REG_BASE) : '0;

   // R10
   onehot_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rom_sel_o, reg_sel_o, mem_sel_o}));

   // R11
   strobe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strb_i |-> !(rom_sel_o || reg_sel_o || mem_sel_o));

   // R7
   rom_needs_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rom_sel_o || reg_sel_o) |-> act_i);

   // R8
   reg_ofs_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_sel_o |-> (int'(reg_ofs_o) < REG_COUNT));

endmodule

// File: rtl/dbg_overlay_top.sv
module dbg_overlay_top #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] REG_BASE  = 16'hFF00,
   parameter int                REG_COUNT = 7,
   parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hFF20,
   localparam int               REG_OFS_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [1:0]           mode_i,
   input  logic                 en_wr_i,
   input  logic                 en_wdata_i,
   input  logic                 ser_trig_i,
   input  logic                 bgnd_trig_i,
   input  logic                 exit_req_i,
   input  logic [ADDR_W-1:0]    cpu_addr_i,
   input  logic                 cpu_strb_i,
   output logic                 dbg_active_o,
   output logic                 dbg_enabled_o,
   output logic                 rom_sel_o,
   output logic                 reg_sel_o,
   output logic [REG_OFS_W-1:0] reg_ofs_o,
   output logic                 mem_sel_o
);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("dbg_overlay_top: ADDR_W out of range");
   end
   if (REG_COUNT < 1) begin : g_bad_cnt
      $error("dbg_overlay_top: REG_COUNT must be positive");
   end
   if (longint'(REG_BASE) + longint'(REG_COUNT) > longint'(ROM_BASE)) begin : g_bad_map
      $error("dbg_overlay_top: register window overlaps ROM");
   end

   logic act;

   dbg_mode_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode_i),
      .en_wr_i     (en_wr_i),
      .en_wdata_i  (en_wdata_i),
      .ser_trig_i  (ser_trig_i),
      .bgnd_trig_i (bgnd_trig_i),
      .exit_req_i  (exit_req_i),
      .act_o       (act),
      .en_o        (dbg_enabled_o)
   );

   dbg_addr_decode #(
      .ADDR_W    (ADDR_W),
      .REG_BASE  (REG_BASE),
      .REG_COUNT (REG_COUNT),
      .ROM_BASE  (ROM_BASE)
   ) u_dec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act),
      .addr_i    (cpu_addr_i),
      .strb_i    (cpu_strb_i),
      .rom_sel_o (rom_sel_o),
      .reg_sel_o (reg_sel_o),
      .reg_ofs_o (reg_ofs_o),
      .mem_sel_o (mem_sel_o)
   );

   assign dbg_active_o = act;

   // R1
   boot_state_chk: assert property (@(posedge clk_i)
      ($rose(rst_ni) && mode_i == 2'b10) |-> (dbg_active_o && dbg_enabled_o));

endmodule

// File: tb/dbg_overlay_top_tb_top.sv
module dbg_overlay_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 16;
   localparam int RCNT = 7;
   localparam logic [AW-1:0] RBASE = 16'hFF00;
   localparam logic [AW-1:0] MBASE = 16'hFF20;

   logic          clk = 1'b0;
   logic          rst_ni;
   logic [1:0]    mode_i;
   logic          en_wr_i, en_wdata_i, ser_trig_i, bgnd_trig_i, exit_req_i;
   logic [AW-1:0] cpu_addr_i;
   logic          cpu_strb_i;
   logic          dbg_active_o, dbg_enabled_o, rom_sel_o, reg_sel_o, mem_sel_o;
   logic [2:0]    reg_ofs_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [1:0] m_mode;
   logic       m_en, m_act;
   string      st_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_overlay_top #(.ADDR_W(AW), .REG_BASE(RBASE), .REG_COUNT(RCNT), .ROM_BASE(MBASE)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
      .ser_trig_i(ser_trig_i), .bgnd_trig_i(bgnd_trig_i), .exit_req_i(exit_req_i),
      .cpu_addr_i(cpu_addr_i), .cpu_strb_i(cpu_strb_i), .dbg_active_o(dbg_active_o),
      .dbg_enabled_o(dbg_enabled_o), .rom_sel_o(rom_sel_o), .reg_sel_o(reg_sel_o),
      .reg_ofs_o(reg_ofs_o), .mem_sel_o(mem_sel_o));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   // expected {rom, reg, mem, ofs[2:0]}
   function automatic logic [5:0] exp_sel(input logic act, input logic [AW-1:0] a, input logic s);
      if (!s) return 6'b0;
      if (!act || a < RBASE) return {3'b001, 3'b000};
      if (a >= MBASE) return {3'b100, 3'b000};
      if (a <= RBASE + AW'(RCNT - 1)) return {3'b010, 3'(a - RBASE)};
      return 6'b0;
   endfunction

   function automatic string sel_tag(input logic act, input logic [AW-1:0] a, input logic s);
      if (!s) return "R11";
      if (!act || a < RBASE) return "R10";
      if (a >= MBASE) return "R7";
      if (a <= RBASE + AW'(RCNT - 1)) return "R8";
      return "R9";
   endfunction

   task automatic do_reset(input logic [1:0] md);
      rst_ni = 1'b0; mode_i = md;
      en_wr_i = 0; en_wdata_i = 0; ser_trig_i = 0; bgnd_trig_i = 0; exit_req_i = 0;
      cpu_addr_i = '0; cpu_strb_i = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_ni = 1'b1;
      m_mode = md; m_en = (md == 2'b10); m_act = (md == 2'b10);
      #1;
      chk("R1 active", {31'b0, dbg_active_o}, {31'b0, m_act});
      chk("R1 enabled", {31'b0, dbg_enabled_o}, {31'b0, m_en});
   endtask

   // called at negedge; drives, checks, advances model over one edge
   task automatic step(input logic wr, input logic wd, input logic st, input logic bt,
                       input logic ex, input logic [AW-1:0] a, input logic s);
      logic nact, nen;
      en_wr_i = wr; en_wdata_i = wd; ser_trig_i = st; bgnd_trig_i = bt;
      exit_req_i = ex; cpu_addr_i = a; cpu_strb_i = s;
      #1;
      chk({sel_tag(m_act, a, s), " selects"},
          {26'b0, rom_sel_o, reg_sel_o, mem_sel_o, reg_ofs_o}, {26'b0, exp_sel(m_act, a, s)});
      if (m_act) nact = !ex;
      else       nact = m_en && (st || bt) && (m_mode != 2'b11);
      nen = (!m_act && !nact && wr) ? wd : m_en;
      if (m_act && ex)                        st_tag = "R6";
      else if (!m_act && (st || bt) && m_mode == 2'b11) st_tag = "R5";
      else if (!m_act && (st || bt) && !m_en) st_tag = "R4";
      else if (!m_act && (st || bt))          st_tag = "R3";
      else if (wr)                            st_tag = "R2";
      else                                    st_tag = "R6";
      @(posedge clk);
      m_act = nact; m_en = nen;
      @(negedge clk);
      #1;
      chk({st_tag, " active"}, {31'b0, dbg_active_o}, {31'b0, m_act});
      chk({st_tag, " enabled"}, {31'b0, dbg_enabled_o}, {31'b0, m_en});
   endtask

   function automatic logic [AW-1:0] rnd_addr();
      int r = $urandom_range(0, 99);
      if (r < 60) return {8'hFF, 8'($urandom_range(0, 255))};
      if (r < 70) return 16'hFEF8 + AW'($urandom_range(0, 15));
      return AW'($urandom);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1D5E_0042));
      // directed: special single-chip boots active, boundary addresses
      do_reset(2'b10);
      step(0,0,0,0,0,16'hFEFF,1);  // R10
      step(0,0,0,0,0,16'hFF00,1);  // R8 ofs 0
      step(0,0,0,0,0,16'hFF06,1);  // R8 ofs 6
      step(0,0,0,0,0,16'hFF07,1);  // R9
      step(0,0,0,0,0,16'hFF1F,1);  // R9
      step(0,0,0,0,0,16'hFF20,1);  // R7
      step(0,0,0,0,0,16'hFFFF,0);  // R11
      step(1,0,0,0,0,16'hFFFF,1);  // R2 write ignored while active
      step(0,0,1,1,1,16'hFF20,1);  // R6 exit beats trigger
      step(0,0,0,0,0,16'hFF20,1);  // R10 overlay gone
      step(0,0,0,0,1,16'hFF03,1);  // R6 exit while inactive
      step(0,0,0,1,0,16'hFF03,1);  // R3 background instruction
      step(0,0,0,0,1,16'hFF03,1);  // R8 then exit
      step(1,0,1,0,0,16'h0000,1);  // R2 write ignored in activating cycle
      // normal mode: disabled, triggers ignored until enabled
      do_reset(2'b00);
      step(0,0,1,1,0,16'hFF20,1);  // R4
      step(1,1,0,0,0,16'hFF20,1);  // R2
      step(0,0,1,0,0,16'hFF20,1);  // R3 serial trigger
      step(0,0,0,0,0,16'hFF20,1);  // R7
      // special peripheral: enabled but triggers ignored
      do_reset(2'b11);
      step(1,1,0,0,0,16'h1234,1);  // R2
      step(0,0,1,1,0,16'hFF20,1);  // R5
      step(0,0,0,0,0,16'hFF20,1);  // R5 / R10
      // random phases, one per mode
      for (int md = 0; md < 4; md++) begin
         do_reset(2'(md));
         for (int i = 0; i < 1500; i++) begin
            step($urandom_range(0,9) == 0, $urandom_range(0,3) != 0,
                 $urandom_range(0,11) == 0, $urandom_range(0,11) == 0,
                 $urandom_range(0,15) == 0, rnd_addr(), $urandom_range(0,4) != 0);
         end
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule